// File: doc/BRIEF.md
# Serial Lane Test-Mode Controller

This block sits in one lane of a serial sample transmitter. It chooses what is fed to the scrambler and 8b/10b encoder: either framed sample octets or a pseudo-random octet stream. It also chooses what is handed to the serializer: the encoded 10-bit symbol, a constant zero word, a zero/one toggle word, or a pseudo-random 10-bit word. Every word passes through an optional bit inversion and is blanked when the lane is powered down. The block also exports which serializer clock edge is to be used. One 8-bit control register configures all of this. The scrambler, the encoder, frame assembly and the serializer sit outside the block and appear here only as ports.

Software writes the control register at any time. A write does not change the datapath until the next symbol boundary, which is marked by `sym_tick`, so no output word mixes two settings. Each tick captures the incoming octet and symbol, steps two PRBS7 generators (polynomial x^7 + x^6 + 1, seeded all ones) and loads a new output word. The outputs are registered and change only on the clock edge of a tick.

Control register layout (`cfg`): bit 0 = power-down (1 = off); bit 1 = serializer edge (1 = negative); bit 2 = polarity (1 = invert); bits 5:4 = output mode (00 encoder, 01 zero, 10 toggle, 11 PRBS); bit 6 = scrambler source (1 = PRBS); bits 7 and 3 unused.

The output state machine has the states ST_ENC, ST_ZERO, ST_TOG, ST_PRBS and ST_OFF. On every tick the next state comes from the pending register. A set power-down bit goes to ST_OFF. Otherwise mode 00 goes to ST_ENC, 01 to ST_ZERO, 10 to ST_TOG and 11 to ST_PRBS. Without a tick the state is held. Reset enters ST_ENC.

Top module: `lane_test_ctrl`

## Requirements
- R1: After reset, cfg_rdata, lane_word, scr_octet, ser_clk_neg and lane_off are all zero.
- R2: A write loads the register on that clock edge. cfg_rdata then returns the written value with bits 7 and 3 forced to zero.
- R3: Outputs change only on a clock edge where sym_tick is high. That edge uses the register value held before the edge, so a write on the same edge takes effect at the following tick.
- R4: With mode 00, lane_word is the enc_symbol sampled at the tick, XOR the polarity mask.
- R5: With mode 01, lane_word is 0 before polarity is applied.
- R6: With mode 10, successive ticks give 0x000, 0x001, 0x000, and so on before polarity, starting at 0x000 on the first tick after any tick in another mode.
- R7: With mode 11, lane_word is the next 10 bits of a PRBS7 sequence. The state is 7 bits, seeded 7'h7F. Each bit is s[6]^s[5]; the state then shifts left with that bit entering at bit 0. The first bit of each word lands in bit 9. The generator steps on every tick that is not powered down, whatever the mode.
- R8: scr_octet is the frame_octet sampled at the tick when bit 6 = 0. When bit 6 = 1 it is the next 8 bits of a second, independent PRBS7 generator, built with the same rule and seed and with the first bit in bit 7.
- R9: With bit 2 = 1, all 10 bits of lane_word are inverted after mode selection. For example, toggle mode then gives 0x3FF, 0x3FE.
- R10: ser_clk_neg follows bit 1 of the register, as applied at the last tick.
- R11: With bit 0 = 1 at a tick, lane_word and scr_octet are 0 with no inversion and lane_off is 1. Both PRBS generators and the toggle phase are frozen, and they resume from where they stopped once the lane is back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register readback |
| sym_tick | input | 1 | Symbol boundary strobe |
| frame_octet | input | 8 | Framed sample octet |
| scr_octet | output | 8 | Octet to scrambler and encoder |
| enc_symbol | input | 10 | Encoded symbol from the 8b/10b encoder |
| lane_word | output | 10 | Word to the serializer |
| ser_clk_neg | output | 1 | Serializer clock edge select (1 = negative) |
| lane_off | output | 1 | Lane is powered down |

## Verification
The bench builds the block with its default widths: a 10-bit symbol, an 8-bit octet and the all-ones PRBS seed. With these values the random register writes reach every mode and flag combination, and the PRBS words can be compared bit by bit against a model inside the bench. Random tick gaps and writes that land on a tick edge exercise the rule that a setting applies only at the next boundary. Directed sequences cover the start of the toggle pattern, the inverted toggle words, and PRBS and toggle freezing across power-down.

// File: rtl/lane_ctl_pkg.sv
package lane_ctl_pkg;
    localparam int CFG_W    = 8;
    localparam int B_PD     = 0;
    localparam int B_EDGE   = 1;
    localparam int B_POL    = 2;
    localparam int B_MODE_L = 4;
    localparam int B_SRC    = 6;
    localparam logic [CFG_W-1:0] CFG_MASK = 8'h77;

    typedef enum logic [1:0] {
        MODE_ENC  = 2'b00,
        MODE_ZERO = 2'b01,
        MODE_TOG  = 2'b10,
        MODE_PRBS = 2'b11
    } lane_mode_e;

    typedef enum logic [2:0] {
        ST_ENC,
        ST_ZERO,
        ST_TOG,
        ST_PRBS,
        ST_OFF
    } lane_st_e;
endpackage

// File: rtl/lane_cfg_reg.sv
module lane_cfg_reg #(
    parameter int                 W    = 8,
    parameter logic [W-1:0]       MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  value <= '0;
        else if (we) value <= wdata & MASK;
    end

    // R2: readback reflects the last write, unused bits cleared
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (value == ($past(wdata) & MASK)));
endmodule

// File: rtl/lane_prbs.sv
module lane_prbs #(
    parameter int         W    = 10,
    parameter logic [6:0] SEED = 7'h7F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] word
);
    logic [6:0]   lfsr;
    logic [6:0]   lfsr_nx;
    logic [W-1:0] word_nx;

    always_comb begin
        logic [6:0] t;
        logic       nb;
        t = lfsr;
        word_nx = '0;
        for (int i = 0; i < W; i++) begin
            nb = t[6] ^ t[5];
            t  = {t[5:0], nb};
            word_nx[W-1-i] = nb;
        end
        lfsr_nx = t;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr <= SEED;
            word <= '0;
        end else if (en) begin
            lfsr <= lfsr_nx;
            word <= word_nx;
        end
    end

    // R7: the generator never locks up in the all-zero state
    a_r7_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != 7'd0);
    // R11: a frozen generator keeps its word
    a_r11_prbs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(word));
endmodule

// File: rtl/lane_test_ctrl.sv
module lane_test_ctrl
    import lane_ctl_pkg::*;
#(
    parameter int         SYM_W = 10,
    parameter int         OCT_W = 8,
    parameter logic [6:0] SEED  = 7'h7F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             sym_tick,
    input  logic [OCT_W-1:0] frame_octet,
    output logic [OCT_W-1:0] scr_octet,
    input  logic [SYM_W-1:0] enc_symbol,
    output logic [SYM_W-1:0] lane_word,
    output logic             ser_clk_neg,
    output logic             lane_off
);
    logic [CFG_W-1:0] pend;
    lane_mode_e       pend_mode;
    lane_st_e         state, nxt;
    logic             prbs_en;
    logic [SYM_W-1:0] prbs_sym;
    logic [OCT_W-1:0] prbs_oct;
    logic [SYM_W-1:0] enc_q;
    logic [OCT_W-1:0] frame_q;
    logic             pol_q, src_q, edge_q, tog_q, tog_nxt;
    logic [SYM_W-1:0] pre_pol;

    lane_cfg_reg #(.W(CFG_W), .MASK(CFG_MASK)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .value(pend)
    );
    assign cfg_rdata = pend;
    assign pend_mode = lane_mode_e'(pend[B_MODE_L+1:B_MODE_L]);
    assign prbs_en   = sym_tick && !pend[B_PD];

    lane_prbs #(.W(SYM_W), .SEED(SEED)) u_prbs_sym (
        .clk(clk), .rst_n(rst_n), .en(prbs_en), .word(prbs_sym)
    );
    lane_prbs #(.W(OCT_W), .SEED(SEED)) u_prbs_oct (
        .clk(clk), .rst_n(rst_n), .en(prbs_en), .word(prbs_oct)
    );

    // next-state selection from the pending register
    always_comb begin
        if (pend[B_PD]) nxt = ST_OFF;
        else begin
            unique case (pend_mode)
                MODE_ENC:  nxt = ST_ENC;
                MODE_ZERO: nxt = ST_ZERO;
                MODE_TOG:  nxt = ST_TOG;
                MODE_PRBS: nxt = ST_PRBS;
                default:   nxt = ST_ENC;
            endcase
        end
    end

    // state register, advanced only at symbol boundaries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= ST_ENC;
        else if (sym_tick) state <= nxt;
    end

    // per-boundary captures and toggle phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_q   <= '0;
            frame_q <= '0;
            pol_q   <= 1'b0;
            src_q   <= 1'b0;
            edge_q  <= 1'b0;
            tog_q   <= 1'b0;
            tog_nxt <= 1'b0;
        end else if (sym_tick) begin
            enc_q   <= enc_symbol;
            frame_q <= frame_octet;
            pol_q   <= pend[B_POL];
            src_q   <= pend[B_SRC];
            edge_q  <= pend[B_EDGE];
            tog_q   <= tog_nxt;
            if (pend_mode != MODE_TOG) tog_nxt <= 1'b0;
            else if (!pend[B_PD])      tog_nxt <= ~tog_nxt;
        end
    end

    // outputs decoded from the current state
    always_comb begin
        pre_pol  = '0;
        lane_off = 1'b0;
        unique case (state)
            ST_ENC:  pre_pol = enc_q;
            ST_ZERO: pre_pol = '0;
            ST_TOG:  pre_pol = {{(SYM_W-1){1'b0}}, tog_q};
            ST_PRBS: pre_pol = prbs_sym;
            ST_OFF:  lane_off = 1'b1;
            default: pre_pol = '0;
        endcase
        if (lane_off)   lane_word = '0;
        else if (pol_q) lane_word = ~pre_pol;
        else            lane_word = pre_pol;
        if (lane_off)   scr_octet = '0;
        else if (src_q) scr_octet = prbs_oct;
        else            scr_octet = frame_q;
    end
    assign ser_clk_neg = edge_q;

    // R3: no output moves without a boundary
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_tick |=> ($stable(lane_word) && $stable(scr_octet) && $stable(ser_clk_neg)));
    // R10: edge select follows the register at the boundary
    a_r10_edge: assert property (@(posedge clk) disable iff (!rst_n)
        sym_tick |=> (ser_clk_neg == $past(pend[B_EDGE])));
    // R11: power-down at a boundary blanks both datapaths
    a_r11_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_tick && pend[B_PD]) |=> (lane_word == '0 && scr_octet == '0 && lane_off));
    // R6: staying in toggle mode flips the toggle bit every boundary
    a_r6_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_tick && state == ST_TOG && nxt == ST_TOG) |=> (tog_q != $past(tog_q)));
endmodule

// File: tb/tb_lane_test_ctrl.sv
module tb_lane_test_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       sym_tick = 1'b0;
    logic [7:0] frame_octet = '0;
    logic [7:0] scr_octet;
    logic [9:0] enc_symbol = '0;
    logic [9:0] lane_word;
    logic       ser_clk_neg;
    logic       lane_off;

    int total = 0;
    int bad   = 0;

    // bench model
    logic [7:0] m_pend = '0;
    logic [6:0] m_s10 = 7'h7F;
    logic [6:0] m_s8  = 7'h7F;
    logic       m_tn  = 1'b0;
    logic [9:0] m_word = '0;
    logic [7:0] m_scr  = '0;
    logic       m_neg = 1'b0;
    logic       m_off = 1'b0;
    logic [1:0] m_mode = 2'b00;

    always #10 clk = ~clk;

    lane_test_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sym_tick(sym_tick), .frame_octet(frame_octet),
        .scr_octet(scr_octet), .enc_symbol(enc_symbol), .lane_word(lane_word),
        .ser_clk_neg(ser_clk_neg), .lane_off(lane_off)
    );

    function automatic logic [9:0] prbs_bits(ref logic [6:0] s, input int n);
        logic [9:0] w;
        logic nb;
        w = '0;
        for (int i = 0; i < n; i++) begin
            nb = s[6] ^ s[5];
            s  = {s[5:0], nb};
            w  = {w[8:0], nb};
        end
        return w;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string word_tag(input logic off, input logic [1:0] md);
        if (off) return "R11 lane_word";
        case (md)
            2'b00:   return "R4 lane_word";
            2'b01:   return "R5 lane_word";
            2'b10:   return "R6 lane_word";
            default: return "R7 lane_word";
        endcase
    endfunction

    // one clock: drive, update model at the edge, compare at the negedge
    task automatic step(input logic we, input logic [7:0] wd, input logic tk,
                        input logic [7:0] fo, input logic [9:0] es);
        logic [7:0] p;
        logic [9:0] w10;
        logic [7:0] w8;
        logic [9:0] pre;
        cfg_we = we; cfg_wdata = wd; sym_tick = tk; frame_octet = fo; enc_symbol = es;
        @(posedge clk);
        p = m_pend;
        if (tk) begin
            m_mode = p[5:4];
            m_off  = p[0];
            m_neg  = p[1];
            if (!p[0]) begin
                w10 = prbs_bits(m_s10, 10);
                w8  = prbs_bits(m_s8, 8)[7:0];
            end else begin
                w10 = '0; w8 = '0;
            end
            case (p[5:4])
                2'b00:   pre = es;
                2'b01:   pre = '0;
                2'b10:   pre = {9'd0, m_tn};
                default: pre = w10;
            endcase
            m_word = p[0] ? 10'd0 : (p[2] ? ~pre : pre);
            m_scr  = p[0] ? 8'd0 : (p[6] ? w8 : fo);
            if (p[5:4] != 2'b10) m_tn = 1'b0;
            else if (!p[0])      m_tn = ~m_tn;
        end
        if (we) m_pend = wd & 8'h77;
        @(negedge clk);
        cfg_we = 1'b0; sym_tick = 1'b0;
        chk(word_tag(m_off, m_mode), {6'd0, lane_word}, {6'd0, m_word});
        chk(m_off ? "R11 scr_octet" : "R8 scr_octet", {8'd0, scr_octet}, {8'd0, m_scr});
        chk("R10 ser_clk_neg", {15'd0, ser_clk_neg}, {15'd0, m_neg});
        chk("R11 lane_off", {15'd0, lane_off}, {15'd0, m_off});
        chk("R2 cfg_rdata", {8'd0, cfg_rdata}, {8'd0, m_pend});
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [9:0] hold;
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cfg_rdata", {8'd0, cfg_rdata}, 16'd0);
        chk("R1 lane_word", {6'd0, lane_word}, 16'd0);
        chk("R1 scr_octet", {8'd0, scr_octet}, 16'd0);
        chk("R1 ser_clk_neg", {15'd0, ser_clk_neg}, 16'd0);
        chk("R1 lane_off", {15'd0, lane_off}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: unused bits read as zero
        step(1'b1, 8'hFF, 1'b0, 8'h00, 10'h000);
        chk("R2 mask", {8'd0, cfg_rdata}, 16'h0077);

        // R3: a write landing on a tick edge applies one tick later
        step(1'b1, 8'h20, 1'b1, 8'h5A, 10'h155);
        chk("R3 old setting used", {15'd0, lane_off}, 16'd1);
        step(1'b0, 8'h00, 1'b0, 8'h00, 10'h000);
        chk("R3 no tick no change", {6'd0, lane_word}, 16'd0);

        // R6: toggle starts at zero
        step(1'b0, 8'h00, 1'b1, 8'h00, 10'h000);
        chk("R6 first", {6'd0, lane_word}, 16'h000);
        step(1'b0, 8'h00, 1'b1, 8'h00, 10'h000);
        chk("R6 second", {6'd0, lane_word}, 16'h001);

        // R9: inverted toggle
        step(1'b1, 8'h24, 1'b0, 8'h00, 10'h000);
        step(1'b0, 8'h00, 1'b1, 8'h00, 10'h000);
        chk("R9 inv zero", {6'd0, lane_word}, 16'h3FF);
        step(1'b0, 8'h00, 1'b1, 8'h00, 10'h000);
        chk("R9 inv one", {6'd0, lane_word}, 16'h3FE);

        // R11: power-down freezes toggle phase and PRBS
        step(1'b1, 8'h25, 1'b0, 8'h00, 10'h000);
        repeat (4) step(1'b0, 8'h00, 1'b1, 8'h00, 10'h000);
        step(1'b1, 8'h24, 1'b0, 8'h00, 10'h000);
        step(1'b0, 8'h00, 1'b1, 8'h00, 10'h000);
        chk("R11 toggle resumes", {6'd0, lane_word}, 16'h3FF);
        step(1'b1, 8'h70, 1'b1, 8'h00, 10'h000);
        step(1'b0, 8'h00, 1'b1, 8'h00, 10'h000);
        hold = lane_word;
        step(1'b0, 8'h00, 1'b0, 8'h00, 10'h000);
        chk("R3 prbs hold", {6'd0, lane_word}, {6'd0, hold});

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic we;
            logic tk;
            we = ($urandom_range(0, 9) == 0);
            tk = ($urandom_range(0, 2) != 0);
            step(we, 8'($urandom), tk, 8'($urandom), 10'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule